// File: doc/BRIEF.md
# Pseudorandom Pattern Bit-Error-Ratio Tester

This block is a built-in error-ratio tester for one serial lane on a parallel word interface. A pattern generator produces a maximal-length sequence from a 15-bit shift register with the polynomial x^15 + x^14 + 1 (period 32767). It sends one W-bit word per clock, with the most significant bit first in time. A per-bit injection mask can flip chosen transmit bits so that the error path can be exercised on purpose. The words go out raw, with no line coding or checksum.

On the receive side a self-synchronising checker loads its replica register from the first 15 received bits and then predicts every following bit. It compares each received word with the prediction and reports how many bits differ. When errors pile up within a short block of bits, it declares loss of lock and reseeds from the incoming data.

A measurement window opens on a start pulse. It accumulates mismatched bits and compared bits in saturating counters. It closes when the error count passes a programmed target (typically 100, the point where a measurement becomes statistically useful) or when the bit count reaches a bit budget. The done flag then stays high and the counters freeze until the next start.

Top module: `prbs_bert`

## Requirements
- R1: From the first clock after reset, tx_valid is high on every cycle. With inj_mask at zero, the bit stream read word after word (bit W-1 first) satisfies b[n] = b[n-14] XOR b[n-15].
- R2: Each set bit of inj_mask inverts the same bit position of the word launched on that clock edge. In loopback, each such bit adds exactly one to err_count.
- R3: Once the valid received words since reset (or since loss of lock) hold at least 15 bits, locked goes high. With W=16 this takes one word. On a clean loopback, err_count stays at zero, and after a loss of lock the checker relocks on its own.
- R4: Each valid word compared while locked adds the number of bit positions where rx_data differs from the predicted word to err_count, and adds W to bit_count, while a window is open.
- R5: Lock is judged over consecutive blocks of 64 bits (4 words at W=16), counted from the moment of locking. If more than 8 errors fall in one block, locked drops and the checker reseeds. With 8 or fewer per block, it stays locked.
- R6: The window closes when err_count exceeds err_target. done rises, and both counters then hold their values.
- R7: The window closes when bit_count reaches max_bits (greater or equal).
- R8: A start pulse clears err_count, bit_count and done on that edge and opens a new window, even when a window is already open. done stays high until the next start.
- R9: err_count and bit_count saturate at all ones instead of wrapping.
- R10: A cycle with rx_valid low is not compared or counted, and the replica does not advance in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new measurement window |
| err_target | input | CW | Error count that must be exceeded to close the window |
| max_bits | input | CW | Bit budget that closes the window |
| inj_mask | input | W | Bits to invert in the next transmit word |
| tx_valid | output | 1 | Transmit word is valid |
| tx_data | output | W | Transmit word, bit W-1 first in time |
| rx_valid | input | 1 | Receive word is valid |
| rx_data | input | W | Receive word, bit W-1 first in time |
| locked | output | 1 | Checker replica is synchronised |
| err_count | output | CW | Mismatched bits in the current window |
| bit_count | output | CW | Compared bits in the current window |
| done | output | 1 | Window closed |

## Verification
The checker is driven by a loopback of the transmitted words through a bench buffer, and several input patterns are applied to it. A clean stream shows that replica prediction and lock are right. Sparse random flips, injected either at the transmitter or on the receive path, show that errors are counted bit by bit and that the lock rule tolerates 8 errors per block. Dense bursts of three errors per word separate a working loss-of-lock and reseed from a stuck replica. Stalls with rx_valid low show that the replica pauses instead of drifting. Windows closed by the error target, by the bit budget and by counter saturation tell the three ending conditions apart.

// File: rtl/prbs_bert_pkg.sv
package prbs_bert_pkg;
  localparam int PRBS_LEN = 15;
  localparam int TAP_HI   = 14;  // b[n-15]
  localparam int TAP_LO   = 13;  // b[n-14]
  typedef logic [PRBS_LEN-1:0] prbs_state_t;
  localparam prbs_state_t PRBS_SEED = '1;
endpackage

// File: rtl/prbs_bert_step.sv
// Combinational advance of the pattern register by W bits, MSB first in time.
module prbs_bert_step
  import prbs_bert_pkg::*;
#(
  parameter int W = 16
) (
  input  prbs_state_t  cur,
  output logic [W-1:0] bits,
  output prbs_state_t  nxt
);
  always_comb begin
    prbs_state_t s;
    logic        b;
    s    = cur;
    bits = '0;
    for (int i = 0; i < W; i++) begin
      b            = s[TAP_HI] ^ s[TAP_LO];
      bits[W-1-i]  = b;
      s            = {s[PRBS_LEN-2:0], b};
    end
    nxt = s;
  end
endmodule

// File: rtl/prbs_bert_gen.sv
module prbs_bert_gen
  import prbs_bert_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] inj_mask,
  output logic         tx_valid,
  output logic [W-1:0] tx_data
);
  prbs_state_t  st, st_nxt;
  logic [W-1:0] pattern;

  prbs_bert_step #(.W(W)) step_i (.cur(st), .bits(pattern), .nxt(st_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PRBS_SEED;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      st       <= st_nxt;
      tx_valid <= 1'b1;
      tx_data  <= pattern ^ inj_mask;
    end
  end

  assert_tx_valid_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> tx_valid);
endmodule

// File: rtl/prbs_bert_chk.sv
module prbs_bert_chk
  import prbs_bert_pkg::*;
#(
  parameter int W        = 16,
  parameter int LOCK_WIN = 64,
  parameter int LOCK_MAX = 8,
  localparam int PW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [W-1:0]  rx_data,
  output logic          locked,
  output logic          cmp_valid,
  output logic [PW-1:0] cmp_errs
);
  localparam int WIN_WORDS = (LOCK_WIN + W - 1) / W;
  localparam int WCW       = $clog2(WIN_WORDS + 1);
  localparam int EW        = $clog2(LOCK_MAX + W + 1);
  localparam int SCW       = $clog2(PRBS_LEN + W + 1);

  function automatic logic [PW-1:0] popcount(input logic [W-1:0] v);
    logic [PW-1:0] c;
    c = '0;
    for (int i = 0; i < W; i++) c = c + PW'(v[i]);
    return c;
  endfunction

  function automatic prbs_state_t shift_in(input prbs_state_t s, input logic [W-1:0] w);
    for (int i = 0; i < W; i++) s = {s[PRBS_LEN-2:0], w[W-1-i]};
    return s;
  endfunction

  prbs_state_t    st, st_pred;
  logic [W-1:0]   pred;
  logic [SCW-1:0] seed_cnt;
  logic [WCW-1:0] win_cnt;
  logic [EW-1:0]  win_errs;

  prbs_bert_step #(.W(W)) step_i (.cur(st), .bits(pred), .nxt(st_pred));

  // named internal events
  logic [PW-1:0] word_errs;
  logic [EW-1:0] win_sum;
  logic          lose_lock, win_last, seed_done;
  assign word_errs = popcount(rx_data ^ pred);
  assign win_sum   = win_errs + EW'(word_errs);
  assign lose_lock = win_sum > EW'(LOCK_MAX);
  assign win_last  = win_cnt == WCW'(WIN_WORDS - 1);
  assign seed_done = (seed_cnt + SCW'(W)) >= SCW'(PRBS_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PRBS_SEED;
      locked    <= 1'b0;
      seed_cnt  <= '0;
      win_cnt   <= '0;
      win_errs  <= '0;
      cmp_valid <= 1'b0;
      cmp_errs  <= '0;
    end else begin
      cmp_valid <= 1'b0;
      if (rx_valid) begin
        if (!locked) begin
          st <= shift_in(st, rx_data);
          if (seed_done) begin
            locked   <= 1'b1;
            seed_cnt <= '0;
          end else begin
            seed_cnt <= seed_cnt + SCW'(W);
          end
          win_cnt  <= '0;
          win_errs <= '0;
        end else begin
          cmp_valid <= 1'b1;
          cmp_errs  <= word_errs;
          st        <= st_pred;
          if (lose_lock) begin
            locked   <= 1'b0;
            win_cnt  <= '0;
            win_errs <= '0;
          end else if (win_last) begin
            win_cnt  <= '0;
            win_errs <= '0;
          end else begin
            win_cnt  <= win_cnt + WCW'(1);
            win_errs <= win_sum;
          end
        end
      end
    end
  end

  assert_cmp_needs_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> $past(locked));
  assert_cmp_errs_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> cmp_errs <= PW'(W));
  assert_win_errs_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> win_errs <= EW'(LOCK_MAX));
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !cmp_valid);
endmodule

// File: rtl/prbs_bert_meas.sv
module prbs_bert_meas #(
  parameter int W  = 16,
  parameter int CW = 48,
  localparam int PW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] err_target,
  input  logic [CW-1:0] max_bits,
  input  logic          cmp_valid,
  input  logic [PW-1:0] cmp_errs,
  output logic [CW-1:0] err_count,
  output logic [CW-1:0] bit_count,
  output logic          done
);
  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CW] ? '1 : s[CW-1:0];
  endfunction

  logic          running;
  logic [CW-1:0] err_n, bit_n;
  logic          hit_err, hit_bits;
  assign err_n    = sat_add(err_count, CW'(cmp_errs));
  assign bit_n    = sat_add(bit_count, CW'(W));
  assign hit_err  = err_n > err_target;
  assign hit_bits = bit_n >= max_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      done      <= 1'b0;
      err_count <= '0;
      bit_count <= '0;
    end else if (start) begin
      running   <= 1'b1;
      done      <= 1'b0;
      err_count <= '0;
      bit_count <= '0;
    end else if (running && cmp_valid) begin
      err_count <= err_n;
      bit_count <= bit_n;
      if (hit_err || hit_bits) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (err_count == '0 && bit_count == '0 && !done));
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  assert_frozen_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(err_count) && $stable(bit_count));
  assert_end_reason_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (err_count > err_target || bit_count >= max_bits));
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    running && !start |=> bit_count >= $past(bit_count) && err_count >= $past(err_count));
endmodule

// File: rtl/prbs_bert.sv
module prbs_bert #(
  parameter int W        = 16,
  parameter int CW       = 48,
  parameter int LOCK_WIN = 64,
  parameter int LOCK_MAX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] err_target,
  input  logic [CW-1:0] max_bits,
  input  logic [W-1:0]  inj_mask,
  output logic          tx_valid,
  output logic [W-1:0]  tx_data,
  input  logic          rx_valid,
  input  logic [W-1:0]  rx_data,
  output logic          locked,
  output logic [CW-1:0] err_count,
  output logic [CW-1:0] bit_count,
  output logic          done
);
  localparam int PW = $clog2(W + 1);

  logic          cmp_valid;
  logic [PW-1:0] cmp_errs;

  prbs_bert_gen #(.W(W)) gen_i (
    .clk(clk), .rst_n(rst_n), .inj_mask(inj_mask),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  prbs_bert_chk #(.W(W), .LOCK_WIN(LOCK_WIN), .LOCK_MAX(LOCK_MAX)) chk_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .locked(locked), .cmp_valid(cmp_valid), .cmp_errs(cmp_errs)
  );

  prbs_bert_meas #(.W(W), .CW(CW)) meas_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .err_target(err_target), .max_bits(max_bits),
    .cmp_valid(cmp_valid), .cmp_errs(cmp_errs),
    .err_count(err_count), .bit_count(bit_count), .done(done)
  );
endmodule

// File: tb/prbs_bert_tb_top.sv
`timescale 1ns/1ps
module prbs_bert_tb_top;
  localparam int W  = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n, start, rx_valid;
  logic [CW-1:0] err_target, max_bits, err_count, bit_count;
  logic [W-1:0]  inj_mask, tx_data, rx_data;
  logic          tx_valid, locked, done;

  always #2 clk = ~clk;  // 250 MHz

  prbs_bert #(.W(W), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .err_target(err_target),
    .max_bits(max_bits), .inj_mask(inj_mask), .tx_valid(tx_valid),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .locked(locked), .err_count(err_count), .bit_count(bit_count), .done(done)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [W-1:0] txbuf [0:4095];
  int           wr = 0, rd = 0;
  logic         rx_stall = 1'b0;
  logic [W-1:0] rx_flip = '0;
  bit           saw_unlock = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ones(input logic [W-1:0] v);
    int c = 0;
    while (v != 0) begin v &= v - 1'b1; c++; end
    return c;
  endfunction

  // loopback through a buffer, inputs change 1 ns after the edge
  initial begin
    rx_valid = 1'b0;
    rx_data  = '0;
    forever begin
      @(posedge clk); #1;
      if (tx_valid) begin txbuf[wr % 4096] = tx_data; wr++; end
      if (!rx_stall && rd < wr) begin
        rx_valid = 1'b1;
        rx_data  = txbuf[rd % 4096] ^ rx_flip;
        rd++;
      end else begin
        rx_valid = 1'b0;
      end
    end
  end

  initial begin
    logic prev = 1'b0;
    forever begin
      @(posedge clk); #1.5;
      if (rst_n && prev && !locked) saw_unlock = 1;
      prev = locked;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    int n = 0;
    while (!done && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int exp_err;
    logic [CW-1:0] b1, e1;
    bit bits [0:1599];
    int nbad;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; inj_mask = '0;
    err_target = 16'd100; max_bits = 16'd800;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 tx_valid in reset", tx_valid, 0);
    check("R3 locked in reset", locked, 0);
    check("R8 done in reset", done, 0);
    check("R4 err_count in reset", err_count, 0);
    check("R4 bit_count in reset", bit_count, 0);
    @(negedge clk);
    check("R1 tx_valid after reset", tx_valid, 1);
    repeat (6) @(negedge clk);
    check("R3 locked after seeding", locked, 1);

    // R1: pattern recurrence over 100 clean words
    while (wr < 100) @(negedge clk);
    for (int w = 0; w < 100; w++)
      for (int k = 0; k < W; k++) bits[w*W + k] = txbuf[w][W-1-k];
    nbad = 0;
    for (int n = 15; n < 1600; n++)
      if (bits[n] != (bits[n-14] ^ bits[n-15])) nbad++;
    check("R1 recurrence violations", nbad, 0);

    // R7 / R3: clean window closed by bit budget
    pulse_start();
    wait_done(200);
    check("R7 done on bit budget", done, 1);
    check("R7 bit_count at budget", bit_count, 800);
    check("R3 clean loopback errors", err_count, 0);
    repeat (10) @(negedge clk);
    check("R8 done held", done, 1);
    check("R8 bit_count held", bit_count, 800);

    // R2 / R4 / R5: sparse random errors, window left open
    err_target = 16'hFFFF; max_bits = 16'hFFFF;
    pulse_start();
    check("R8 start clears bits", bit_count, 0);
    exp_err = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      inj_mask = ($urandom % 2) ? (W'(1) << ($urandom % W)) : '0;
      exp_err += ones(inj_mask);
    end
    @(negedge clk) inj_mask = '0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      rx_flip = ($urandom % 3 == 0) ? (W'(1) << ($urandom % W)) : '0;
      exp_err += ones(rx_flip);
    end
    @(negedge clk) rx_flip = '0;
    repeat (10) @(negedge clk);
    check("R2 R4 injected and flipped errors", err_count, exp_err);
    check("R5 lock kept at <=8 per block", locked, 1);
    check("R4 bit_count word multiple", bit_count % W, 0);

    // R10: stalls do not count and do not desync
    rx_stall = 1'b1;
    repeat (3) @(negedge clk);
    b1 = bit_count;
    repeat (5) @(negedge clk);
    check("R10 no count while idle", bit_count, b1);
    rx_stall = 1'b0;
    e1 = err_count;
    repeat (12) @(negedge clk);
    check("R10 replica paused, no errors", err_count, e1);
    check("R10 still locked", locked, 1);

    // R8: restart mid-window
    pulse_start();
    check("R8 restart clears errors", err_count, 0);
    check("R8 restart clears bits", bit_count, 0);

    // R6: closed by error target
    err_target = 16'd20;
    pulse_start();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      inj_mask = W'(1) << ($urandom % W);
    end
    @(negedge clk) inj_mask = '0;
    repeat (8) @(negedge clk);
    check("R6 done on error target", done, 1);
    check("R6 err_count frozen at target+1", err_count, 21);
    b1 = bit_count;
    repeat (6) @(negedge clk);
    check("R6 bits frozen after done", bit_count, b1);

    // R5: dense burst loses lock, then relock
    err_target = 16'hFFFF;
    pulse_start();
    saw_unlock = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      inj_mask = W'(16'h0111) << ($urandom % 4);
    end
    @(negedge clk) inj_mask = '0;
    repeat (30) @(negedge clk);
    check("R5 lock lost on burst", saw_unlock, 1);
    check("R3 relocked", locked, 1);
    e1 = err_count;
    repeat (20) @(negedge clk);
    check("R3 clean after relock", err_count, e1);

    // R9: saturation of bit counter closes the window at all ones
    max_bits = 16'hFFFF;
    pulse_start();
    wait_done(5000);
    check("R9 done via saturation", done, 1);
    check("R9 bit_count saturated", bit_count, 16'hFFFF);
    check("R9 long clean run errors", err_count, 0);

    finish_run();
  end
endmodule